// File: doc/BRIEF.md
# Target Header Corruption Guard

This block sits in the receive path of a bus target that answers on a dynamic address. After every START or repeated START it collects the first frame, the address header, and checks it for one specific fault: a broadcast header that arrives with one bit wrong. A target that cannot tell whether a header was a broadcast cannot know whether the controller has just switched the bus into a high-data-rate mode. The block treats this ambiguity as fatal. It raises a sticky error flag and a sticky interrupt flag, and it holds a suppress line that tells the rest of the target to stop decoding.

While suppressing, the block waits for one of two signs that the bus is back in normal single-data-rate signalling.

- **Exit pattern:** four SDA falling edges with SCL low, followed by a STOP. This releases the target at once.
- **Idle interval:** SCL and SDA stay high together for an interval tied to the slowest high-data-rate clock. This is 60 µs: 60 % of the 100 µs period of a 10 kHz clock. After this interval has been seen, the next STOP or repeated START releases the target.

Software clears each flag separately with its own strobe.

Top module: `tgt_hdr_guard`

## Requirements
- R1: After a synchronous reset, `hdr_err_o`, `bus_irq_o` and `suppress_o` are all 0.
- R2: While `dyn_addr_vld_i` is 0, no header sets either flag.
- R3: The header is the first 8 bits after a START strobe, each sampled on an SCL rising edge. Bit 7 is sent first and bit 0 (R/W, 1 = read) is sent last. Eight header byte values are errors: 8'h7C, 8'hBC, 8'hDC, 8'hEC, 8'hF4, 8'hF8 and 8'hFE (write), and 8'hFD (read). On the edge that samples the eighth bit of one of these, both `hdr_err_o` and `bus_irq_o` become 1.
- R4: Header bytes 8'hFC (broadcast write) and 8'hFF (two bits off), as well as ordinary target addresses, leave both flags unchanged.
- R5: `suppress_o` rises on the same edge as the flags and stays at 1 until recovery ends.
- R6: The block ignores bits after the eighth until the next START. During suppression, headers do not set any flag.
- R7: The flags never clear by themselves. `clr_err_i` clears only `hdr_err_o` and `clr_irq_i` clears only `bus_irq_o`. A new detection in the same cycle as a clear wins.
- R8: While suppressing, the block counts clock cycles in which SCL and SDA are both 1, and any 0 on either line restarts the count. Once the count has reached IDLE_CYC, the next START or STOP strobe drops `suppress_o`. Before that point, START and STOP strobes are ignored.
- R9: While suppressing, four SDA falling edges with SCL low, with no SCL rise between them, followed by a STOP strobe drop `suppress_o` on the edge after the STOP.
- R10: IDLE_CYC = (CLK_HZ / 1 000 000) × IDLE_US. The defaults are IDLE_US = 60 and CLK_HZ = 200 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| start_i | input | 1 | One-cycle START / repeated START strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| dyn_addr_vld_i | input | 1 | Target holds a dynamic address |
| clr_err_i | input | 1 | Software clear for the error flag |
| clr_irq_i | input | 1 | Software clear for the interrupt flag |
| hdr_err_o | output | 1 | Sticky header-corruption flag |
| bus_irq_o | output | 1 | Sticky bus-error interrupt flag |
| suppress_o | output | 1 | Stop decoding bus traffic |

## Verification
The bench builds the block with CLK_HZ = 1 000 000 and IDLE_US = 60. This makes the idle window only 60 cycles long. The bench can therefore run all eight corrupted headers through recovery, and probe the window one cycle short and exactly full, well within the run limit. With the default 200 MHz setting the window is 12 000 cycles. The bench never uses this value, so its arithmetic is covered by R10 alone.

// File: rtl/tgt_hdr_pkg.sv
// Shared types and helpers for the target header corruption guard.
package tgt_hdr_pkg;

    typedef enum logic [1:0] {
        ST_DECODE  = 2'd0,   // normal header decoding
        ST_RECOVER = 2'd1,   // suppressing, looking for idle or exit pattern
        ST_BUSOK   = 2'd2    // idle seen, waiting for START or STOP
    } guard_st_e;

    // Broadcast address with the write bit, as a header byte.
    localparam logic [7:0] BCAST_WR = 8'hFC;

    // A header is corrupt when exactly one bit differs from broadcast/write.
    function automatic logic hdr_is_corrupt(input logic [7:0] b);
        return $countones(b ^ BCAST_WR) == 1;
    endfunction

endpackage

// File: rtl/tgt_hdr_capture.sv
// Header capture: shifts in the first HDR_BITS bits after each START,
// sampled on SCL rising edges, MSB first. Assumes start_i is a one-cycle
// strobe. Idle (no header in progress) after reset until the first START.
module tgt_hdr_capture #(
    parameter int HDR_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                scl_rise_i,
    input  logic                sda_i,
    output logic                hdr_done_o,
    output logic [HDR_BITS-1:0] hdr_byte_o
);
    localparam int CW = $clog2(HDR_BITS + 1);

    logic [CW-1:0]       bit_cnt;
    logic [HDR_BITS-2:0] shreg;

    // Count and shift header bits; a START rearms the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= CW'(HDR_BITS);
            shreg   <= '0;
        end else if (start_i) begin
            bit_cnt <= '0;
        end else if (scl_rise_i && bit_cnt < CW'(HDR_BITS)) begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg   <= {shreg[HDR_BITS-3:0], sda_i};
        end
    end

    // Header complete on the rising edge that carries the last bit.
    always_comb begin
        hdr_done_o = scl_rise_i && !start_i && (bit_cnt == CW'(HDR_BITS - 1));
        hdr_byte_o = {shreg, sda_i};
    end

    // R6: never more than HDR_BITS bits are taken per START
    a_r6_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CW'(HDR_BITS));
endmodule

// File: rtl/tgt_idle_timer.sv
// Idle timer: counts consecutive cycles with SCL and SDA both high while
// enabled; any low level or disable restarts it. Saturates at CNT_MAX.
module tgt_idle_timer #(
    parameter int CNT_MAX = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic idle_ok_o
);
    localparam int CW = $clog2(CNT_MAX + 1);

    logic [CW-1:0] cnt;

    // Count high-high cycles, restart on any low or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || !(scl_i && sda_i)) begin
            cnt <= '0;
        end else if (cnt < CW'(CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Idle window reached.
    always_comb idle_ok_o = (cnt == CW'(CNT_MAX));

    // R8: a low level on either line restarts the window
    a_r8_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !(scl_i && sda_i) |=> cnt == '0);
endmodule

// File: rtl/tgt_exit_watch.sv
// Exit pattern watch: while enabled, counts SDA falling edges seen with
// SCL low; an SCL rise before the count completes restarts it. Once the
// count completes it holds, and a STOP strobe then reports the exit.
module tgt_exit_watch #(
    parameter int FALLS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic scl_i,
    input  logic scl_rise_i,
    input  logic sda_fall_i,
    input  logic stop_i,
    output logic exit_o
);
    localparam int CW = $clog2(FALLS + 1);

    logic [CW-1:0] fall_cnt;

    // Track SDA falls under SCL low until the required number is seen.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            fall_cnt <= '0;
        end else if (fall_cnt < CW'(FALLS)) begin
            if (sda_fall_i && !scl_i) begin
                fall_cnt <= fall_cnt + 1'b1;
            end else if (scl_rise_i) begin
                fall_cnt <= '0;
            end
        end
    end

    // Exit recognized on the STOP after the full pattern.
    always_comb exit_o = en_i && stop_i && (fall_cnt == CW'(FALLS));

    // R9: the count only advances by one edge at a time
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (fall_cnt <= $past(fall_cnt) + 1'b1) || !en_i);
endmodule

// File: rtl/tgt_hdr_guard.sv
// Top: detects single-bit-corrupted broadcast headers while the target
// holds a dynamic address, sets sticky error and interrupt flags, and runs
// recovery (suppress decoding; release on exit pattern + STOP, or on the
// START/STOP that follows an idle window). Assumes scl_i/sda_i are already
// synchronized and start_i/stop_i are one-cycle strobes.
module tgt_hdr_guard
    import tgt_hdr_pkg::*;
#(
    parameter int CLK_HZ    = 200_000_000,
    parameter int IDLE_US   = 60,
    parameter int HDR_BITS  = 8,
    parameter int EXIT_FALL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic dyn_addr_vld_i,
    input  logic clr_err_i,
    input  logic clr_irq_i,
    output logic hdr_err_o,
    output logic bus_irq_o,
    output logic suppress_o
);
    localparam int IDLE_CYC = (CLK_HZ / 1_000_000) * IDLE_US;

    guard_st_e           state, state_nx;
    logic                scl_q, sda_q;
    logic                scl_rise, sda_fall;
    logic                hdr_done;
    logic [HDR_BITS-1:0] hdr_byte;
    logic                hdr_bad;
    logic                idle_ok;
    logic                exit_hit;
    logic                recov_en;
    logic                err_q, irq_q;

    // Previous line levels for edge detection; idle bus reads high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Line edges.
    always_comb begin
        scl_rise = scl_i && !scl_q;
        sda_fall = !sda_i && sda_q;
        recov_en = (state == ST_RECOVER);
    end

    tgt_hdr_capture #(.HDR_BITS(HDR_BITS)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .scl_rise_i (scl_rise),
        .sda_i      (sda_i),
        .hdr_done_o (hdr_done),
        .hdr_byte_o (hdr_byte)
    );

    tgt_idle_timer #(.CNT_MAX(IDLE_CYC)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (recov_en),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .idle_ok_o (idle_ok)
    );

    tgt_exit_watch #(.FALLS(EXIT_FALL)) u_exit (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (recov_en),
        .scl_i      (scl_i),
        .scl_rise_i (scl_rise),
        .sda_fall_i (sda_fall),
        .stop_i     (stop_i),
        .exit_o     (exit_hit)
    );

    // Corrupted header seen while decoding with a dynamic address held.
    always_comb hdr_bad = (state == ST_DECODE) && hdr_done && dyn_addr_vld_i
                          && hdr_is_corrupt(hdr_byte[7:0]);

    // Recovery sequencing.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DECODE:  if (hdr_bad)              state_nx = ST_RECOVER;
            ST_RECOVER: if (exit_hit)             state_nx = ST_DECODE;
                        else if (idle_ok)         state_nx = ST_BUSOK;
            ST_BUSOK:   if (start_i || stop_i)    state_nx = ST_DECODE;
            default:                              state_nx = ST_DECODE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_DECODE;
        else        state <= state_nx;
    end

    // Sticky flags, each with its own clear; detection wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (hdr_bad)        err_q <= 1'b1;
            else if (clr_err_i) err_q <= 1'b0;
            if (hdr_bad)        irq_q <= 1'b1;
            else if (clr_irq_i) irq_q <= 1'b0;
        end
    end

    // Outputs.
    always_comb begin
        hdr_err_o  = err_q;
        bus_irq_o  = irq_q;
        suppress_o = (state != ST_DECODE);
    end

    // R2: no detection without a dynamic address
    a_r2_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !dyn_addr_vld_i |=> !$rose(hdr_err_o));
    // R5: suppression accompanies a new detection
    a_r5_suppress_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_err_o) |-> suppress_o);
    // R7: error flag holds without its clear
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err_o && !clr_err_i |=> hdr_err_o);
    // R7: interrupt flag holds without its clear
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bus_irq_o && !clr_irq_i |=> bus_irq_o);
    // R7: error clear takes effect when no detection collides
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err_i && !hdr_bad |=> !hdr_err_o);
    // R7: interrupt clear leaves the error flag alone
    a_r7_irq_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
        clr_irq_i && !clr_err_i && hdr_err_o |=> hdr_err_o);
    // R9: exit pattern releases decoding on the next cycle
    a_r9_exit_release: assert property (@(posedge clk) disable iff (!rst_n)
        exit_hit |=> !suppress_o);
endmodule

// File: tb/tgt_hdr_guard_tb_top.sv
`timescale 1ns/100ps
module tgt_hdr_guard_tb_top;
    localparam int CLK_HZ = 1_000_000;
    localparam int IDLE_US = 60;
    localparam int N_IDLE = 60;   // R10: (1 MHz / 1 MHz) * 60

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, start = 1'b0, stop = 1'b0;
    logic dav = 1'b0, clr_err = 1'b0, clr_irq = 1'b0;
    logic hdr_err, bus_irq, suppress;

    int tests = 0, fails = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    tgt_hdr_guard #(.CLK_HZ(CLK_HZ), .IDLE_US(IDLE_US)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .start_i(start), .stop_i(stop), .dyn_addr_vld_i(dav),
        .clr_err_i(clr_err), .clr_irq_i(clr_irq),
        .hdr_err_o(hdr_err), .bus_irq_o(bus_irq), .suppress_o(suppress));

    // ---------------- behavioural reference model ----------------
    int m_mode;            // 0 decode, 1 recovering, 2 idle confirmed
    int m_high_run, m_falls, m_bits;
    int hdr_bits_q[$];
    bit m_scl_prev, m_sda_prev, m_err, m_irq;

    function automatic bit bad_hdr(input int b);
        case (b)
            8'h7C, 8'hBC, 8'hDC, 8'hEC, 8'hF4, 8'hF8, 8'hFE, 8'hFD: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_high_run = 0; m_falls = 0; m_bits = 8;
            hdr_bits_q.delete();
            m_scl_prev = 1; m_sda_prev = 1; m_err = 0; m_irq = 0;
        end else begin
            bit rise, fall, done, bad, exit_now, idle_seen;
            int hv, nmode;
            rise = scl && !m_scl_prev;
            fall = !sda && m_sda_prev;
            done = 0; hv = 0;
            if (start) begin
                m_bits = 0; hdr_bits_q.delete();
            end else if (rise && m_bits < 8) begin
                hdr_bits_q.push_back(int'(sda));
                m_bits++;
                if (m_bits == 8) begin
                    done = 1;
                    foreach (hdr_bits_q[i]) hv = hv * 2 + hdr_bits_q[i];
                end
            end
            bad = (m_mode == 0) && done && dav && bad_hdr(hv);
            idle_seen = (m_high_run >= N_IDLE);
            exit_now = (m_mode == 1) && (m_falls == 4) && stop;
            nmode = m_mode;
            if (m_mode == 0 && bad) nmode = 1;
            else if (m_mode == 1 && exit_now) nmode = 0;
            else if (m_mode == 1 && idle_seen) nmode = 2;
            else if (m_mode == 2 && (start || stop)) nmode = 0;
            if (m_mode != 1) m_falls = 0;
            else if (m_falls < 4) begin
                if (fall && !scl) m_falls++;
                else if (rise) m_falls = 0;
            end
            if (m_mode != 1 || !(scl && sda)) m_high_run = 0;
            else if (m_high_run < N_IDLE) m_high_run++;
            if (bad) begin m_err = 1; m_irq = 1; end
            else begin
                if (clr_err) m_err = 0;
                if (clr_irq) m_irq = 0;
            end
            m_mode = nmode;
            m_scl_prev = scl; m_sda_prev = sda;
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            tests++;
            if (hdr_err !== m_err || bus_irq !== m_irq || suppress !== (m_mode != 0)) begin
                fails++;
                $display("FAIL model R3/R5/R7/R8/R9 t=%0t act err=%b irq=%b sup=%b exp err=%b irq=%b sup=%b",
                         $time, hdr_err, bus_irq, suppress, m_err, m_irq, m_mode != 0);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic do_start();
        sda = 1'b0; start = 1'b1; step(1); start = 1'b0; step(1);
    endtask

    task automatic do_stop();
        scl = 1'b1; sda = 1'b1; stop = 1'b1; step(1); stop = 1'b0; step(1);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; sda = b[i]; step(2);
            scl = 1'b1; step(2);
        end
        scl = 1'b0; step(1);
    endtask

    task automatic header(input logic [7:0] b);
        do_start(); send_byte(b);
    endtask

    task automatic exit_pattern();
        scl = 1'b0; sda = 1'b1; step(1);
        for (int i = 0; i < 4; i++) begin
            sda = 1'b0; step(1); sda = 1'b1; step(1);
        end
        sda = 1'b0; step(1); scl = 1'b1; step(1);
        do_stop();
    endtask

    // Watchdog: counts as a failed check and still reports.
    initial begin
        #(5.0 * 190000);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] bad_list [8];
        bad_list = '{8'h7C, 8'hBC, 8'hDC, 8'hEC, 8'hF4, 8'hF8, 8'hFE, 8'hFD};
        step(3);
        rst_n = 1'b1; step(1);
        cmp_on = 1'b1;
        chk("R1 err after reset", hdr_err, 1'b0);
        chk("R1 irq after reset", bus_irq, 1'b0);
        chk("R1 suppress after reset", suppress, 1'b0);

        // R2: no dynamic address, corrupt header ignored
        header(8'h7C); do_stop();
        chk("R2 no err without address", hdr_err, 1'b0);
        chk("R2 decode kept without address", suppress, 1'b0);

        dav = 1'b1;
        // R4: clean broadcast, two-bit-off and ordinary addresses
        header(8'hFC); do_stop();
        chk("R4 broadcast write clean", hdr_err, 1'b0);
        header(8'hFF); do_stop();
        chk("R4 two-bit-off ignored", hdr_err, 1'b0);
        header(8'hA4); do_stop();
        chk("R4 plain address ignored", bus_irq, 1'b0);
        // R6: data after a good header is not a header
        header(8'hA0); send_byte(8'h7C); send_byte(8'hFD); do_stop();
        chk("R6 data bytes ignored", hdr_err, 1'b0);

        for (int k = 0; k < 8; k++) begin
            header(bad_list[k]);
            chk("R3 err set on corrupt header", hdr_err, 1'b1);
            chk("R3 irq set on corrupt header", bus_irq, 1'b1);
            chk("R5 suppress on detection", suppress, 1'b1);
            // R6: headers during suppression are not decoded
            header(8'hFC);
            chk("R6 still suppressing", suppress, 1'b1);
            if (k % 2 == 0) begin
                // R8: window one short, then a low, then STOP: still held
                scl = 1'b1; sda = 1'b1; step(N_IDLE - 1);
                sda = 1'b0; step(1);
                do_stop();
                chk("R8 short idle keeps suppress", suppress, 1'b1);
                // R10: full window then STOP releases
                scl = 1'b1; sda = 1'b1; step(N_IDLE + 2);
                chk("R10 idle alone does not release", suppress, 1'b1);
                do_stop();
                chk("R8 STOP after idle releases", suppress, 1'b0);
            end else begin
                exit_pattern();
                chk("R9 exit pattern releases", suppress, 1'b0);
            end
            // R7: clears are independent and sticky otherwise
            step(5);
            chk("R7 err sticky", hdr_err, 1'b1);
            clr_irq = 1'b1; step(1); clr_irq = 1'b0; step(1);
            chk("R7 irq cleared", bus_irq, 1'b0);
            chk("R7 err kept on irq clear", hdr_err, 1'b1);
            clr_err = 1'b1; step(1); clr_err = 1'b0; step(1);
            chk("R7 err cleared", hdr_err, 1'b0);
        end

        // R8: START also releases after idle window
        header(8'h7C);
        scl = 1'b1; sda = 1'b1; step(N_IDLE + 3);
        do_start();
        chk("R8 START after idle releases", suppress, 1'b0);
        chk("R7 err stays after release", hdr_err, 1'b1);
        scl = 1'b1; sda = 1'b1; step(4);

        cmp_on = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule